// File: doc/BRIEF.md
# Delayed-Commit Result Buffer with Supply-Noise Rollback

This block is the commit stage of a core whose front end runs on tight timing margins. Finished instructions arrive in program order. Each carries a tag, a result and the cycle in which it completed. The block keeps every result in a small in-order buffer and does not let it reach architectural state until a fixed verification window has passed since completion. The window is set equal to the delay of the supply-voltage sensor. While an entry is inside the window it is speculative. Once the window has passed it is verified and may commit.

When the sensor reports a violation, every entry still inside the window is dropped, together with any completion offered in that cycle. A one-cycle flush names the tag from which fetch must restart. Verified entries stay in the buffer and commit as usual. No register or memory image is saved. Recovery relies only on the buffer and the flush path.

After each flush, a restart throttle limits commit to one instruction per fixed number of cycles for a fixed period, and then returns to full rate. The block keeps its own timebase. `now` is 0 in the first cycle after reset is released and rises by one every cycle. Completion stamps are given in this timebase.

Top module: `dcr_commit_buffer`

## Requirements
- R1: Results commit in the order they were accepted, and `cmt_tag` and `cmt_data` equal the tag and data that were accepted.
- R2: An entry stamped `c` can only be chosen for commit in a cycle where `now - c >= VERIFY_LAT` (modulo 2^16; default 5, and 3 is also supported). `cmt_valid` rises in the following cycle. When the throttle is off, a verified oldest entry commits every cycle.
- R3: While DEPTH entries are held, `cmp_ready` is low and an offered completion is not taken. It must be offered again.
- R4: A `viol_pulse` discards every buffered entry whose age `now - c` is below VERIFY_LAT, and also the completion offered in the same cycle. Older entries are kept and later commit in order.
- R5: `flush_valid` is high for exactly the cycle after each `viol_pulse`. `flush_tag` is the tag of the oldest discarded buffered entry. If no buffered entry was discarded, it is the tag one past the youngest accepted (0 after reset). Tags are sequential modulo 2^TAG_W.
- R6: `throttle_on` is high for THROTTLE_LEN cycles, starting with the flush cycle. While it is high, a commit chosen in one cycle is followed by THROTTLE_GAP-1 cycles in which no commit is chosen.
- R7: A `viol_pulse` that arrives while the throttle is active issues a new flush and restarts the throttle period at its full length.
- R8: After reset, `cmt_valid`, `flush_valid` and `throttle_on` are low and `cmp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | Completion offered this cycle |
| cmp_ready | output | 1 | Buffer has room for a completion |
| cmp_tag | input | TAG_W | Tag of the completing instruction |
| cmp_data | input | DATA_W | Result of the completing instruction |
| cmp_cycle | input | 16 | Completion cycle in the block's timebase |
| viol_pulse | input | 1 | Supply sensor reports a violation |
| cmt_valid | output | 1 | A verified result commits this cycle |
| cmt_tag | output | TAG_W | Tag of the committing result |
| cmt_data | output | DATA_W | Committing result |
| flush_valid | output | 1 | Rollback request, one cycle |
| flush_tag | output | TAG_W | Restart tag for fetch |
| throttle_on | output | 1 | Restart throttle active |

## Verification
The assertions check on every cycle that occupancy never exceeds the depth and never grows across a violation cycle. They also check that each flush follows a violation by one cycle and that the throttle is active in every flush cycle. A further assertion checks that a throttled commit is never followed at once by another one. The bench checks the rest against a behavioural model, cycle by cycle. This covers the commit order and timing relative to the verification window, the restart tag chosen at rollback, that verified entries survive it, the length of the throttle period, and its reload after a second violation. Directed checks confirm the restart tag in steady streaming and in an empty buffer, back-pressure once the throttle lets the buffer fill, and the throttle length after a single violation and after a repeated one.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int CYC_W = 16;
  typedef logic [CYC_W-1:0] cyc_t;

  // age in the wrapping timebase compared against the window
  function automatic logic window_passed(input cyc_t now, input cyc_t stamp,
                                         input int unsigned lat);
    cyc_t age;
    age = now - stamp;
    return 32'(age) >= lat;
  endfunction
endpackage

// File: rtl/dcr_payload_ram.sv
module dcr_payload_ram #(
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [TAG_W-1:0]  wtag,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  output logic [TAG_W-1:0]  rtag_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [TAG_W-1:0]  rtag_b
);
  logic [TAG_W-1:0]  tag_mem  [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[waddr]  <= wtag;
      data_mem[waddr] <= wdata;
    end
  end

  assign rtag_a  = tag_mem[raddr_a];
  assign rdata_a = data_mem[raddr_a];
  assign rtag_b  = tag_mem[raddr_b];
endmodule

// File: rtl/dcr_age_scan.sv
module dcr_age_scan #(
  parameter int DEPTH      = 16,
  parameter int VERIFY_LAT = 5,
  localparam int AW        = $clog2(DEPTH),
  localparam int CW        = AW + 1
) (
  input  logic               clk,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  dcr_pkg::cyc_t      wstamp,
  input  logic [AW-1:0]      head,
  input  logic [CW-1:0]      count,
  input  dcr_pkg::cyc_t      now,
  output logic               head_ok,
  output logic               spec_any,
  output logic [AW-1:0]      spec_off
);
  dcr_pkg::cyc_t stamp [DEPTH];
  logic [DEPTH-1:0] spec;

  always_ff @(posedge clk) begin
    if (we) stamp[waddr] <= wstamp;
  end

  // position i counts from the oldest entry
  for (genvar i = 0; i < DEPTH; i++) begin : g_pos
    logic [AW-1:0] slot;
    assign slot    = head + AW'(i);
    assign spec[i] = (CW'(i) < count) &&
                     !dcr_pkg::window_passed(now, stamp[slot], VERIFY_LAT);
  end

  always_comb begin
    spec_off = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (spec[i]) spec_off = AW'(i);
    end
  end

  assign spec_any = |spec;
  assign head_ok  = (count != '0) && !spec[0];
endmodule

// File: rtl/dcr_restart_throttle.sv
module dcr_restart_throttle #(
  parameter int GAP = 4,
  parameter int LEN = 32,
  localparam int LW = $clog2(LEN + 1),
  localparam int GW = (GAP > 1) ? $clog2(GAP) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic took,
  output logic active,
  output logic allow
);
  logic [LW-1:0] left;
  logic [GW-1:0] gap;

  assign active = (left != '0);
  assign allow  = !active || (gap == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      left <= '0;
      gap  <= '0;
    end else if (restart) begin
      left <= LW'(LEN);
      gap  <= GW'(GAP - 1);
    end else if (active) begin
      left <= left - 1'b1;
      if (took)            gap <= GW'(GAP - 1);
      else if (gap != '0)  gap <= gap - 1'b1;
    end
  end
endmodule

// File: rtl/dcr_commit_buffer.sv
module dcr_commit_buffer #(
  parameter int TAG_W        = 8,
  parameter int DATA_W       = 32,
  parameter int DEPTH        = 16,
  parameter int VERIFY_LAT   = 5,
  parameter int THROTTLE_GAP = 4,
  parameter int THROTTLE_LEN = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cmp_valid,
  output logic                        cmp_ready,
  input  logic [TAG_W-1:0]            cmp_tag,
  input  logic [DATA_W-1:0]           cmp_data,
  input  logic [dcr_pkg::CYC_W-1:0]   cmp_cycle,
  input  logic                        viol_pulse,
  output logic                        cmt_valid,
  output logic [TAG_W-1:0]            cmt_tag,
  output logic [DATA_W-1:0]           cmt_data,
  output logic                        flush_valid,
  output logic [TAG_W-1:0]            flush_tag,
  output logic                        throttle_on
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [AW-1:0]    head, tail;
  logic [CW-1:0]    count;
  dcr_pkg::cyc_t    now;
  logic [TAG_W-1:0] next_tag;

  logic             head_ok, spec_any, allow, pop, push;
  logic [AW-1:0]    spec_off, spec_pos;
  logic [TAG_W-1:0] head_tag, spec_tag;
  logic [DATA_W-1:0] head_data;

  assign cmp_ready = (count != CW'(DEPTH));
  assign push      = cmp_valid && cmp_ready && !viol_pulse;
  assign pop       = head_ok && allow;
  assign spec_pos  = head + spec_off;

  dcr_payload_ram #(.TAG_W(TAG_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(push), .waddr(tail), .wtag(cmp_tag), .wdata(cmp_data),
    .raddr_a(head), .rtag_a(head_tag), .rdata_a(head_data),
    .raddr_b(spec_pos), .rtag_b(spec_tag)
  );

  dcr_age_scan #(.DEPTH(DEPTH), .VERIFY_LAT(VERIFY_LAT)) u_scan (
    .clk(clk), .we(push), .waddr(tail), .wstamp(cmp_cycle),
    .head(head), .count(count), .now(now),
    .head_ok(head_ok), .spec_any(spec_any), .spec_off(spec_off)
  );

  dcr_restart_throttle #(.GAP(THROTTLE_GAP), .LEN(THROTTLE_LEN)) u_thr (
    .clk(clk), .rst(rst), .restart(viol_pulse), .took(pop),
    .active(throttle_on), .allow(allow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      head        <= '0;
      tail        <= '0;
      count       <= '0;
      now         <= '0;
      next_tag    <= '0;
      cmt_valid   <= 1'b0;
      cmt_tag     <= '0;
      cmt_data    <= '0;
      flush_valid <= 1'b0;
      flush_tag   <= '0;
    end else begin
      now         <= now + 1'b1;
      cmt_valid   <= pop;
      flush_valid <= viol_pulse;
      if (pop) begin
        cmt_tag  <= head_tag;
        cmt_data <= head_data;
        head     <= head + 1'b1;
      end
      if (viol_pulse) begin
        if (spec_any) begin
          tail      <= spec_pos;
          count     <= {1'b0, spec_off} - CW'(pop);
          flush_tag <= spec_tag;
          next_tag  <= spec_tag;
        end else begin
          count     <= count - CW'(pop);
          flush_tag <= next_tag;
        end
      end else begin
        if (push) begin
          tail     <= tail + 1'b1;
          next_tag <= cmp_tag + 1'b1;
        end
        count <= count + CW'(push) - CW'(pop);
      end
    end
  end
endmodule

// File: rtl/dcr_commit_buffer_chk.sv
module dcr_commit_buffer_chk #(
  parameter int DEPTH = 16,
  parameter int GAP   = 4,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          viol_pulse,
  input logic          cmt_valid,
  input logic          flush_valid,
  input logic          throttle_on,
  input logic [CW-1:0] count
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)) else $error("occupancy above depth"); // R3

  AST_VIOL_NO_GROWTH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(viol_pulse)) |-> (count <= $past(count)))
    else $error("occupancy grew across violation"); // R4

  AST_FLUSH_AFTER_VIOL: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (flush_valid == $past(viol_pulse)))
    else $error("flush not aligned to violation"); // R5

  AST_FLUSH_THROTTLES: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> throttle_on) else $error("flush without throttle"); // R6

  if (GAP >= 2) begin : g_gap
    AST_THROTTLE_GAP: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(throttle_on) && throttle_on && cmt_valid) |=> !cmt_valid)
      else $error("back-to-back commit under throttle"); // R6
  end
endmodule

bind dcr_commit_buffer dcr_commit_buffer_chk #(
  .DEPTH(DEPTH), .GAP(THROTTLE_GAP), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .viol_pulse(viol_pulse), .cmt_valid(cmt_valid),
  .flush_valid(flush_valid), .throttle_on(throttle_on), .count(count)
);

// File: tb/dcr_commit_buffer_bench.sv
module dcr_commit_buffer_bench;
  localparam int TW = 8, DW = 32, DEPTH = 16, VL = 5, GAP = 4, LEN = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic cmp_valid = 1'b0, viol_pulse = 1'b0;
  logic [TW-1:0] cmp_tag = '0;
  logic [DW-1:0] cmp_data = '0;
  logic [15:0]   cmp_cycle = '0;
  logic cmp_ready, cmt_valid, flush_valid, throttle_on;
  logic [TW-1:0] cmt_tag, flush_tag;
  logic [DW-1:0] cmt_data;

  dcr_commit_buffer #(.TAG_W(TW), .DATA_W(DW), .DEPTH(DEPTH), .VERIFY_LAT(VL),
    .THROTTLE_GAP(GAP), .THROTTLE_LEN(LEN)) u_dcr_commit_buffer (
    .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_ready(cmp_ready),
    .cmp_tag(cmp_tag), .cmp_data(cmp_data), .cmp_cycle(cmp_cycle),
    .viol_pulse(viol_pulse), .cmt_valid(cmt_valid), .cmt_tag(cmt_tag),
    .cmt_data(cmt_data), .flush_valid(flush_valid), .flush_tag(flush_tag),
    .throttle_on(throttle_on));

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  typedef struct { logic [TW-1:0] tag; logic [DW-1:0] data; int stamp; } ent_t;
  ent_t q[$];
  int m_now = 0, m_left = 0, m_gap = 0;
  logic [TW-1:0] m_next = '0;
  bit e_cv = 0, e_fv = 0, started = 0;
  logic [TW-1:0] e_ctag = '0, e_ftag = '0;
  logic [DW-1:0] e_cdata = '0;

  function automatic bit aged(input int stamp);
    return ((m_now - stamp) & 65535) >= VL;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); m_now = 0; m_left = 0; m_gap = 0; m_next = '0;
      e_cv = 0; e_fv = 0; started = 1;
    end else begin
      bit ok_rate, pop, room;
      ok_rate = (m_left == 0) || (m_gap == 0);
      room = q.size() != DEPTH;
      pop = (q.size() > 0) && aged(q[0].stamp) && ok_rate;
      e_cv = pop;
      if (pop) begin e_ctag = q[0].tag; e_cdata = q[0].data; end
      e_fv = viol_pulse;
      if (viol_pulse) begin
        int k;
        k = -1;
        foreach (q[i]) if (k < 0 && !aged(q[i].stamp)) k = i;
        if (k >= 0) begin
          e_ftag = q[k].tag; m_next = q[k].tag;
          while (q.size() > k) void'(q.pop_back());
        end else e_ftag = m_next;
        if (pop) void'(q.pop_front());
        m_left = LEN; m_gap = GAP - 1;
      end else begin
        if (pop) void'(q.pop_front());
        if (cmp_valid && room) begin
          ent_t e;
          e.tag = cmp_tag; e.data = cmp_data; e.stamp = int'(cmp_cycle);
          q.push_back(e); m_next = cmp_tag + 1'b1;
        end
        if (m_left != 0) begin
          m_left--;
          if (pop) m_gap = GAP - 1; else if (m_gap != 0) m_gap--;
        end
      end
      m_now++;
    end
  end

  logic [TW-1:0] watch_tag = '0;
  bit seen_watch = 0;
  always @(negedge clk) begin
    if (started && !rst) begin
      chk(cmt_valid == e_cv, "R2", "commit valid", cmt_valid, e_cv);
      if (e_cv && cmt_valid) begin
        chk(cmt_tag == e_ctag, "R1", "commit tag", cmt_tag, e_ctag);
        chk(cmt_data == e_cdata, "R1", "commit data", cmt_data, e_cdata);
      end
      chk(cmp_ready == (q.size() != DEPTH), "R3", "ready", cmp_ready, q.size() != DEPTH);
      chk(flush_valid == e_fv, "R5", "flush valid", flush_valid, e_fv);
      if (e_fv && flush_valid) chk(flush_tag == e_ftag, "R5", "flush tag", flush_tag, e_ftag);
      chk(throttle_on == (m_left != 0), "R6", "throttle", throttle_on, m_left != 0);
      if (cmt_valid && cmt_tag == watch_tag) seen_watch = 1;
    end
  end

  // stimulus
  logic [TW-1:0] tg = '0;
  bit acc = 0;
  task automatic cyc(input bit v, input bit x);
    @(negedge clk);
    if (flush_valid) tg = flush_tag; else if (acc) tg = tg + 1'b1;
    cmp_valid = v; viol_pulse = x; cmp_tag = tg;
    cmp_data = {tg, tg ^ 8'h5A, ~tg, tg + 8'd3};
    cmp_cycle = 16'(m_now);
    acc = v && cmp_ready && !x;
  endtask

  task automatic measure_throttle(input string req);
    int on_cnt, thr_cmt;
    bit full_seen;
    on_cnt = throttle_on ? 1 : 0; thr_cmt = 0; full_seen = 0;
    for (int i = 0; i < 3 * LEN && throttle_on; i++) begin
      cyc(1, 0);
      if (throttle_on) on_cnt++;
      if (throttle_on && cmt_valid) thr_cmt++;
      if (!cmp_ready) full_seen = 1;
    end
    chk(on_cnt == LEN, req, "throttle length", on_cnt, LEN);
    chk(thr_cmt <= LEN / GAP + 1, "R6", "throttled commit count", thr_cmt, LEN / GAP + 1);
    chk(full_seen, "R3", "buffer filled under throttle", full_seen, 1);
  endtask

  initial begin
    logic [TW-1:0] tv;
    #(8 * 20000);
    chk(0, "ALL", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [TW-1:0] tv;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk(!cmt_valid && !flush_valid && !throttle_on, "R8", "outputs after reset",
        {cmt_valid, flush_valid, throttle_on}, 0);
    chk(cmp_ready, "R8", "ready after reset", cmp_ready, 1);

    // steady streaming, then violation: R4/R5 restart tag
    for (int i = 0; i < 12; i++) cyc(1, 0);
    cyc(1, 1);
    tv = cmp_tag;
    watch_tag = tv - 8'(VL); seen_watch = 0;
    cyc(1, 0);
    chk(flush_valid, "R5", "flush after violation", flush_valid, 1);
    chk(flush_tag == tv - 8'(VL - 1), "R5", "restart tag in stream", flush_tag, tv - 8'(VL - 1));
    chk(throttle_on, "R6", "throttle with flush", throttle_on, 1);
    measure_throttle("R6");
    chk(seen_watch, "R4", "verified entry kept", seen_watch, 1);

    // repeated violation inside the throttle period
    for (int i = 0; i < 10; i++) cyc(1, 0);
    cyc(1, 1);
    for (int i = 0; i < 10; i++) cyc(1, 0);
    cyc(1, 1);
    cyc(1, 0);
    chk(flush_valid, "R7", "second flush issued", flush_valid, 1);
    measure_throttle("R7");

    // empty buffer: restart tag is one past youngest accepted
    for (int i = 0; i < 60; i++) cyc(0, 0);
    chk(!cmt_valid && cmp_ready, "R2", "drained", {cmt_valid, cmp_ready}, 1);
    cyc(0, 1);
    tv = tg;
    cyc(0, 0);
    chk(flush_tag == tv, "R5", "restart tag when empty", flush_tag, tv);
    for (int i = 0; i < LEN + 20; i++) cyc(i % 3 != 0, 0);
    for (int i = 0; i < 30; i++) cyc(0, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule